// File: doc/BRIEF.md
# Registered Four-Bit Arithmetic and Logic Unit

This block is a small arithmetic and logic unit for a data path that computes one result per clock. Two operands, a mode bit, two select bits and a carry input are taken into a row of flip-flops on every clock edge. From that registered copy, one of two paths produces a result. The arithmetic path shapes the second operand bit by bit into zero, B, the inverse of B, or all ones, and adds it to A and the carry input in a carry-lookahead adder. The logic path picks one of four bitwise functions. A mode-controlled selection sends one of the two results into the output register.

In arithmetic mode the one adder covers transfer, increment, addition, addition with carry, subtraction, ones'-complement addition and decrement. The carry out of the top bit is registered with the result. A new operation can start on every cycle, and each result appears two clock edges after its inputs. A synchronous active-high reset clears every register.

Top module: `nib_alu`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears all input and output registers, so `result` and `carry_out` read 0 after it.
- R2: A vector applied before edge k is captured at edge k. Its result and carry show on the outputs after edge k+1 and not before.
- R3: With `arith_en`=1 and {`sel_hi`,`sel_lo`}=00, {`carry_out`,`result`} equals A + `carry_in`. This is transfer for carry 0 and increment for carry 1, and 15+1 wraps to 0 with carry 1.
- R4: With `arith_en`=1 and {`sel_hi`,`sel_lo`}=01, {`carry_out`,`result`} equals A + B + `carry_in`.
- R5: With `arith_en`=1 and {`sel_hi`,`sel_lo`}=10, {`carry_out`,`result`} equals A + (~B) + `carry_in`. With carry 1 the result is A−B modulo 16, and `carry_out` is 1 exactly when A ≥ B.
- R6: With `arith_en`=1 and {`sel_hi`,`sel_lo`}=11, {`carry_out`,`result`} equals A + 15 + `carry_in`. With carry 0 this is decrement: 0 wraps to 15 with carry 0. With carry 1 it is transfer with carry 1.
- R7: With `arith_en`=0, {`sel_lo`,`carry_in`} picks the bitwise function: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOT A. `sel_hi` has no effect on the result.
- R8: With `arith_en`=0, `carry_out` is 0.
- R9: The adder forms every carry in lookahead form from per-bit propagate (A XOR Y) and generate (A AND Y) terms. Each sum bit is its propagate term XOR its incoming carry.
- R10: A different vector may be applied every cycle. Each result depends only on its own vector, with no effect from the vectors before or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| arith_en | input | 1 | 1 selects arithmetic, 0 selects logic |
| sel_hi | input | 1 | High select bit (arithmetic only) |
| sel_lo | input | 1 | Low select bit |
| carry_in | input | 1 | Adder carry in, or low logic select bit |
| result | output | 4 | Registered result |
| carry_out | output | 1 | Registered carry out of the top bit |

## Verification
Capturing a new vector in the input register and loading the output register with the previous vector's result happen on the same edge. The bench drives a different vector on every cycle through all 4096 combinations of mode, selects, carry and operands. It compares each output pair against a value computed arithmetically for the vector two cycles earlier, so any leak between neighbouring operations shows as a mismatch. Wraparound for increment, decrement and subtraction falls inside that sweep. A separate held-vector step confirms that the result does not appear one edge too early, and a reset in the middle of the stream confirms that both register rows clear.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    // Bitwise function code, formed as {sel_lo, carry_in} in logic mode.
    typedef enum logic [1:0] {
        LF_AND  = 2'b00,
        LF_OR   = 2'b01,
        LF_XOR  = 2'b10,
        LF_NOTA = 2'b11
    } logic_fn_e;

endpackage

// File: rtl/nib_alu_bsel.sv
// Builds the adder's second operand bit by bit: y = b&s0 | ~b&s1.
module nib_alu_bsel #(
    parameter int W = 4
) (
    input  logic [W-1:0] b,
    input  logic         s1,
    input  logic         s0,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = (b[i] & s0) | (~b[i] & s1);
    end
endmodule

// File: rtl/nib_alu_cla.sv
// Carry-lookahead adder: propagate/generate, lookahead carries, sum.
module nib_alu_cla #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] y,
    input  logic         c0,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] p;
    logic [W-1:0] g;
    logic [W:0]   c;

    for (genvar i = 0; i < W; i++) begin : g_pg
        assign p[i] = a[i] ^ y[i];
        assign g[i] = a[i] & y[i];
    end

    // Each carry is a flat sum of products: the generate of each lower bit,
    // qualified by the propagates above it, plus c0 across all of them.
    always_comb begin
        logic acc;
        logic prod;
        c[0] = c0;
        for (int i = 1; i <= W; i++) begin
            acc  = 1'b0;
            prod = 1'b1;
            for (int j = i - 1; j >= 0; j--) begin
                acc  = acc | (prod & g[j]);
                prod = prod & p[j];
            end
            c[i] = acc | (prod & c0);
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_sum
        assign sum[i] = p[i] ^ c[i];
    end
    assign cout = c[W];
endmodule

// File: rtl/nib_alu_logic.sv
// Four-way bitwise function, one selector per bit.
module nib_alu_logic #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    import nib_alu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (logic_fn_e'(fn))
                LF_AND:  y[i] = a[i] & b[i];
                LF_OR:   y[i] = a[i] | b[i];
                LF_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = ~a[i];
            endcase
        end
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         arith_en,
    input  logic         sel_hi,
    input  logic         sel_lo,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic         carry_out
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         m;
        logic         s1;
        logic         s0;
        logic         ci;
        logic [W-1:0] res;
        logic         co;
    } state_t;

    localparam state_t RESET_STATE = '0;

    state_t st_q;
    state_t st_d;

    logic [W-1:0] y_op;
    logic [W-1:0] arith_sum;
    logic         arith_co;
    logic [W-1:0] logic_res;

    nib_alu_bsel #(.W(W)) u_bsel (
        .b  (st_q.b),
        .s1 (st_q.s1),
        .s0 (st_q.s0),
        .y  (y_op)
    );

    nib_alu_cla #(.W(W)) u_cla (
        .a    (st_q.a),
        .y    (y_op),
        .c0   (st_q.ci),
        .sum  (arith_sum),
        .cout (arith_co)
    );

    nib_alu_logic #(.W(W)) u_logic (
        .a  (st_q.a),
        .b  (st_q.b),
        .fn ({st_q.s0, st_q.ci}),
        .y  (logic_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.a   = op_a;
        st_d.b   = op_b;
        st_d.m   = arith_en;
        st_d.s1  = sel_hi;
        st_d.s0  = sel_lo;
        st_d.ci  = carry_in;
        st_d.res = st_q.m ? arith_sum : logic_res;
        st_d.co  = st_q.m & arith_co;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.res;
    assign carry_out = st_q.co;
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         arith_en,
    input logic         sel_hi,
    input logic         sel_lo,
    input logic         carry_in,
    input logic [W-1:0] result,
    input logic         carry_out
);
    localparam int WX = W + 1;

    // Counts clean edges since reset, saturating at 2 (two-edge latency).
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (result == '0 && carry_out == 1'b0));

    // R8
    p_logic_no_carry_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && !$past(arith_en, 2)) |-> (carry_out == 1'b0));

    // R7
    p_not_a_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && !$past(arith_en, 2) && $past(sel_lo, 2) && $past(carry_in, 2))
        |-> (result == ~$past(op_a, 2)));

    // R4 and R2
    p_add_r4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && $past(arith_en, 2) && !$past(sel_hi, 2) && $past(sel_lo, 2))
        |-> ({carry_out, result} == (WX'($past(op_a, 2)) + WX'($past(op_b, 2)) + WX'($past(carry_in, 2)))));

    // R3
    p_transfer_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && $past(arith_en, 2) && !$past(sel_hi, 2) && !$past(sel_lo, 2))
        |-> ({carry_out, result} == (WX'($past(op_a, 2)) + WX'($past(carry_in, 2)))));
endmodule

bind nib_alu nib_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .arith_en  (arith_en),
    .sel_hi    (sel_hi),
    .sel_lo    (sel_lo),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/nib_alu_tb.sv
module nib_alu_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_a, op_b;
    logic       arith_en, sel_hi, sel_lo, carry_in;
    logic [3:0] result;
    logic       carry_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [4:0] exp_q [0:4095];

    always #10 clk = ~clk;

    nib_alu #(.W(4)) u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .arith_en(arith_en), .sel_hi(sel_hi), .sel_lo(sel_lo),
        .carry_in(carry_in), .result(result), .carry_out(carry_out)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual={co,res}=%b expected=%b", tag, act, exp);
        end
    endtask

    // Expected {carry_out,result} from the requirements, plus the tag it checks.
    function automatic logic [4:0] model(input logic [11:0] v);
        logic [3:0] a, b, y;
        logic m, s1, s0, ci;
        {m, s1, s0, ci, a, b} = v;
        if (m) begin
            case ({s1, s0})
                2'b00:   y = 4'd0;   // R3
                2'b01:   y = b;      // R4
                2'b10:   y = ~b;     // R5
                default: y = 4'hF;   // R6
            endcase
            return 5'(a) + 5'(y) + 5'(ci);
        end
        case ({s0, ci})              // R7, R8: carry 0
            2'b00:   return {1'b0, a & b};
            2'b01:   return {1'b0, a | b};
            2'b10:   return {1'b0, a ^ b};
            default: return {1'b0, ~a};
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] v);
        if (!v[11]) return "R7/R8/R10";
        case (v[10:9])
            2'b00:   return "R3/R9/R10";
            2'b01:   return "R4/R9/R10";
            2'b10:   return "R5/R9/R10";
            default: return "R6/R9/R10";
        endcase
    endfunction

    task automatic drive(input logic [11:0] v);
        {arith_en, sel_hi, sel_lo, carry_in, op_a, op_b} = v;
    endtask

    initial begin
        rst = 1'b1;
        drive(12'hFFF);
        repeat (3) @(negedge clk);
        chk("R1 reset state", {carry_out, result}, 5'd0);

        // R2: latency of exactly two edges (transfer of A).
        rst = 1'b0;
        drive({4'b1000, 4'd5, 4'd0});
        repeat (3) @(negedge clk);
        chk("R2 settled", {carry_out, result}, 5'd5);
        drive({4'b1000, 4'd9, 4'd0});
        @(negedge clk);
        chk("R2 not early", {carry_out, result}, 5'd5);
        @(negedge clk);
        chk("R2 on time", {carry_out, result}, 5'd9);

        // Named corner cases.
        drive({4'b1001, 4'd15, 4'd0});               // increment wrap
        repeat (2) @(negedge clk);
        chk("R3 increment wrap", {carry_out, result}, 5'b10000);
        drive({4'b1110, 4'd0, 4'd7});                // decrement wrap
        repeat (2) @(negedge clk);
        chk("R6 decrement wrap", {carry_out, result}, 5'b01111);
        drive({4'b1101, 4'd3, 4'd5});                // 3-5 borrow
        repeat (2) @(negedge clk);
        chk("R5 subtract wrap", {carry_out, result}, 5'b01110);
        drive({4'b0100, 4'hC, 4'hA});                // sel_hi=1, AND
        repeat (2) @(negedge clk);
        chk("R7 sel_hi ignored", {carry_out, result}, 5'b01000);

        // R10: streaming exhaustive sweep, one vector per cycle.
        for (int n = 0; n < 4096 + 2; n++) begin
            if (n < 4096) begin
                exp_q[n] = model(12'(n));
                drive(12'(n));
            end
            if (n >= 2) chk(tag_of(12'(n - 2)), {carry_out, result}, exp_q[n - 2]);
            @(negedge clk);
        end

        // R1: reset in the middle of a stream clears both register rows.
        drive({4'b1011, 4'd9, 4'd9});
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-stream reset", {carry_out, result}, 5'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 input row cleared", {carry_out, result}, 5'd0);
        @(negedge clk);
        chk("R4 after reset", {carry_out, result}, 5'b10011);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule